// File: doc/BRIEF.md
# Stack and Restart-Call Sequencer

This block owns the stack pointer of a small processor whose stack is kept in external byte-wide memory and grows toward lower addresses. A sequencer hands it one command at a time. The block moves the 16-bit values between the stack and the sequencer, one memory byte per cycle. The commands cover saving and restoring a 16-bit word (a register pair, or the accumulator together with its flags), subroutine call and return, a one-byte restart call to one of eight fixed vectors, swapping a register pair with the word on top of the stack, and loading the pointer itself.

The sequencer asserts `cmd_valid` for one cycle while the block is idle. The block then runs its memory cycles and pulses `done` for one cycle. During that cycle the result word, the redirect request (`pc_load`) and the new program-counter value are valid. The sequencer supplies the return address on `cmd_word` for calls and restarts. Restart vectors can also be driven by interrupt hardware.

Top module: `stack_call_unit`

## Requirements
- R1: After reset, `sp_out` equals the parameter `SP_RESET` (default 0000h), and `busy`, `done`, `mem_rd`, `mem_wr` and `pc_load` are low.
- R2: Push (cmd_op 0) writes the high byte of `cmd_word` at SP-1 in the first cycle, then the low byte at SP-2 in the second cycle, and leaves SP reduced by two. There is one access per cycle, and read and write are never asserted together.
- R3: Pop (cmd_op 1) reads the low byte at SP and then the high byte at SP+1. It returns {high, low} on `res_word` and leaves SP increased by two.
- R4: Call (cmd_op 2) pushes `cmd_word` as the return address in the R2 byte order. At completion it asserts `pc_load` with `pc_next` equal to `cmd_target`.
- R5: Return (cmd_op 3) pops a word in the R3 order. At completion it asserts `pc_load` with `pc_next` equal to the popped word.
- R6: Restart (cmd_op 4) pushes `cmd_word` in the R2 byte order and asserts `pc_load` with `pc_next` equal to `cmd_vec` times 8. For vector 7 this gives 0038h.
- R7: Exchange (cmd_op 5) does four accesses in this order: read at SP, read at SP+1, write the high byte of `cmd_word` at SP+1, write the low byte at SP. It returns the old top word on `res_word` and leaves SP unchanged.
- R8: `done` is high for exactly one cycle, in the cycle after the last memory access. For two-access commands this is the third cycle after acceptance; for exchange it is the fifth.
- R9: A `cmd_valid` seen while `busy` is high (including the `done` cycle) has no effect on SP or on memory.
- R10: Command code 7 is ignored: there is no memory access, no `done`, and SP does not change.
- R11: Load-pointer (cmd_op 6) copies `cmd_word` into SP with no memory access and pulses `done` in the first cycle after acceptance.
- R12: Pointer arithmetic wraps modulo 2^16. A push from SP=0001h writes at 0000h and then at FFFFh, and the pop that follows restores SP to 0001h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 call, 3 return, 4 restart, 5 exchange, 6 load pointer, 7 unused) |
| cmd_word | input | 16 | Word to push, return address, register pair to exchange, or new SP |
| cmd_target | input | 16 | Call destination |
| cmd_vec | input | 3 | Restart vector number |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the cycle `mem_rd` is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| busy | output | 1 | High from acceptance through the `done` cycle |
| done | output | 1 | One-cycle completion pulse |
| res_word | output | 16 | Popped or exchanged-out stack word |
| pc_load | output | 1 | Program-counter redirect, valid with `done` |
| pc_next | output | 16 | New program-counter value |
| sp_out | output | 16 | Current stack pointer |

## Verification
The assertions assume that memory returns read data in the same cycle as the read strobe. They also assume that the sequencer never depends on a command being accepted while `busy` is high. The stick-to-SP properties count from the accepting edge, so they rely on `cmd_valid` meaning nothing during a command. The bench's memory model answers reads combinationally from the address. The bench issues each command while the block is idle, except in the one scenario that deliberately holds `cmd_valid` high through a busy command. That scenario then checks that only the original command took effect.

// File: rtl/stack_call_pkg.sv
package stack_call_pkg;

   typedef enum logic [2:0] {
      OP_PUSH  = 3'd0,
      OP_POP   = 3'd1,
      OP_CALL  = 3'd2,
      OP_RET   = 3'd3,
      OP_RST   = 3'd4,
      OP_XTOP  = 3'd5,
      OP_SETSP = 3'd6,
      OP_NONE  = 3'd7
   } stk_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WHI,
      ST_WLO,
      ST_RLO,
      ST_RHI,
      ST_XRLO,
      ST_XRHI,
      ST_XWHI,
      ST_XWLO,
      ST_DONE
   } stk_step_e;

endpackage

// File: rtl/stk_pointer.sv
module stk_pointer #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_i,
   input  logic              dec_i,
   output logic [ADDR_W-1:0] sp_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_o <= RESET_VAL;
      else if (load_i)
         sp_o <= load_val_i;
      else if (dec_i)
         sp_o <= sp_o - ADDR_W'(1);
      else if (inc_i)
         sp_o <= sp_o + ADDR_W'(1);
   end

   // R2: the controller never asks for two pointer moves at once
   p_sp_one_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({load_i, inc_i, dec_i}) <= 1);

endmodule

// File: rtl/stk_vector.sv
module stk_vector #(
   parameter int ADDR_W    = 16,
   parameter int VEC_W     = 3,
   parameter int VEC_SHIFT = 3
) (
   input  logic [VEC_W-1:0]  vec_i,
   output logic [ADDR_W-1:0] addr_o
);

   generate
      if (ADDR_W < VEC_W + VEC_SHIFT) begin : g_bad_cfg
         $error("stk_vector: vector field does not fit the address");
      end
      if (VEC_SHIFT == 0) begin : g_packed
         assign addr_o = ADDR_W'(vec_i);
      end else begin : g_spaced
         assign addr_o = ADDR_W'(vec_i) << VEC_SHIFT;
      end
   endgenerate

endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
   import stack_call_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int WORD_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  stk_op_e           cmd_op_i,
   input  logic [WORD_W-1:0] cmd_word_i,
   input  logic [WORD_W-1:0] cmd_target_i,
   input  logic [WORD_W-1:0] vec_addr_i,
   input  logic [WORD_W-1:0] sp_i,
   output logic              sp_load_o,
   output logic [WORD_W-1:0] sp_load_val_o,
   output logic              sp_inc_o,
   output logic              sp_dec_o,
   output logic [WORD_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [WORD_W-1:0] res_word_o,
   output logic              pc_load_o,
   output logic [WORD_W-1:0] pc_next_o
);

   stk_step_e         step_q, step_d;
   stk_op_e           op_q;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] jump_q;
   logic [WORD_W-1:0] res_q;
   logic              accept;
   logic              cap_lo, cap_hi;
   logic [DATA_W-1:0] word_hi, word_lo;

   assign accept  = (step_q == ST_IDLE) && cmd_valid_i && (cmd_op_i != OP_NONE);
   assign word_hi = word_q[WORD_W-1:DATA_W];
   assign word_lo = word_q[DATA_W-1:0];
   assign cap_lo  = (step_q == ST_RLO) || (step_q == ST_XRLO);
   assign cap_hi  = (step_q == ST_RHI) || (step_q == ST_XRHI);

   function automatic stk_step_e first_step(input stk_op_e op);
      case (op)
         OP_PUSH, OP_CALL, OP_RST: first_step = ST_WHI;
         OP_POP, OP_RET:           first_step = ST_RLO;
         OP_XTOP:                  first_step = ST_XRLO;
         OP_SETSP:                 first_step = ST_DONE;
         default:                  first_step = ST_IDLE;
      endcase
   endfunction

   always_comb begin
      step_d      = step_q;
      mem_rd_o    = 1'b0;
      mem_wr_o    = 1'b0;
      mem_addr_o  = sp_i;
      mem_wdata_o = '0;
      sp_inc_o    = 1'b0;
      sp_dec_o    = 1'b0;
      case (step_q)
         ST_IDLE: begin
            if (accept) step_d = first_step(cmd_op_i);
         end
         ST_WHI: begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = sp_i - WORD_W'(1);
            mem_wdata_o = word_hi;
            sp_dec_o    = 1'b1;
            step_d      = ST_WLO;
         end
         ST_WLO: begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = sp_i - WORD_W'(1);
            mem_wdata_o = word_lo;
            sp_dec_o    = 1'b1;
            step_d      = ST_DONE;
         end
         ST_RLO: begin
            mem_rd_o = 1'b1;
            sp_inc_o = 1'b1;
            step_d   = ST_RHI;
         end
         ST_RHI: begin
            mem_rd_o = 1'b1;
            sp_inc_o = 1'b1;
            step_d   = ST_DONE;
         end
         ST_XRLO: begin
            mem_rd_o = 1'b1;
            step_d   = ST_XRHI;
         end
         ST_XRHI: begin
            mem_rd_o   = 1'b1;
            mem_addr_o = sp_i + WORD_W'(1);
            step_d     = ST_XWHI;
         end
         ST_XWHI: begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = sp_i + WORD_W'(1);
            mem_wdata_o = word_hi;
            step_d      = ST_XWLO;
         end
         ST_XWLO: begin
            mem_wr_o    = 1'b1;
            mem_wdata_o = word_lo;
            step_d      = ST_DONE;
         end
         ST_DONE: step_d = ST_IDLE;
         default: step_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         op_q   <= OP_NONE;
         word_q <= '0;
         jump_q <= '0;
         res_q  <= '0;
      end else begin
         step_q <= step_d;
         if (accept) begin
            op_q   <= cmd_op_i;
            word_q <= cmd_word_i;
            jump_q <= (cmd_op_i == OP_RST) ? vec_addr_i : cmd_target_i;
         end
         if (cap_lo) res_q[DATA_W-1:0]      <= mem_rdata_i;
         if (cap_hi) res_q[WORD_W-1:DATA_W] <= mem_rdata_i;
      end
   end

   assign sp_load_o     = accept && (cmd_op_i == OP_SETSP);
   assign sp_load_val_o = cmd_word_i;
   assign busy_o        = (step_q != ST_IDLE);
   assign done_o        = (step_q == ST_DONE);
   assign res_word_o    = res_q;
   assign pc_load_o     = done_o &&
                          ((op_q == OP_CALL) || (op_q == OP_RET) || (op_q == OP_RST));
   assign pc_next_o     = (op_q == OP_RET) ? res_q : jump_q;

   // R2: one byte per cycle, never read and write together
   p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));

   // R2: a finished push-type command leaves SP two lower
   p_push_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && ((op_q == OP_PUSH) || (op_q == OP_CALL) || (op_q == OP_RST))
      |-> sp_i == $past(sp_i, 2) - WORD_W'(2));

   // R3: a finished pop-type command leaves SP two higher
   p_pop_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && ((op_q == OP_POP) || (op_q == OP_RET))
      |-> sp_i == $past(sp_i, 2) + WORD_W'(2));

   // R7: exchange leaves SP where it started
   p_xtop_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && (op_q == OP_XTOP) |-> sp_i == $past(sp_i, 4));

   // R8: done is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10: idle with no real command means no access and a steady pointer
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !(cmd_valid_i && (cmd_op_i != OP_NONE))
      |-> !mem_rd_o && !mem_wr_o ##1 $stable(sp_i) && !busy_o);

endmodule

// File: rtl/stack_call_unit.sv
module stack_call_unit
   import stack_call_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int VEC_COUNT = 8,
   parameter int VEC_SHIFT = 3,
   parameter logic [2*DATA_W-1:0] SP_RESET = '0,
   localparam int WORD_W = 2 * DATA_W,
   localparam int VEC_W  = $clog2(VEC_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [WORD_W-1:0] cmd_word,
   input  logic [WORD_W-1:0] cmd_target,
   input  logic [VEC_W-1:0]  cmd_vec,
   output logic [WORD_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] res_word,
   output logic              pc_load,
   output logic [WORD_W-1:0] pc_next,
   output logic [WORD_W-1:0] sp_out
);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("stack_call_unit: DATA_W must be at least 4");
      end
      if ((VEC_COUNT < 2) || ((1 << VEC_W) != VEC_COUNT)) begin : g_bad_vec
         $error("stack_call_unit: VEC_COUNT must be a power of two");
      end
   endgenerate

   logic              sp_load, sp_inc, sp_dec;
   logic [WORD_W-1:0] sp_load_val;
   logic [WORD_W-1:0] vec_addr;

   stk_pointer #(
      .ADDR_W    (WORD_W),
      .RESET_VAL (SP_RESET)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (sp_load),
      .load_val_i (sp_load_val),
      .inc_i      (sp_inc),
      .dec_i      (sp_dec),
      .sp_o       (sp_out)
   );

   stk_vector #(
      .ADDR_W    (WORD_W),
      .VEC_W     (VEC_W),
      .VEC_SHIFT (VEC_SHIFT)
   ) u_vec (
      .vec_i  (cmd_vec),
      .addr_o (vec_addr)
   );

   stk_fsm #(
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid_i   (cmd_valid),
      .cmd_op_i      (stk_op_e'(cmd_op)),
      .cmd_word_i    (cmd_word),
      .cmd_target_i  (cmd_target),
      .vec_addr_i    (vec_addr),
      .sp_i          (sp_out),
      .sp_load_o     (sp_load),
      .sp_load_val_o (sp_load_val),
      .sp_inc_o      (sp_inc),
      .sp_dec_o      (sp_dec),
      .mem_addr_o    (mem_addr),
      .mem_wdata_o   (mem_wdata),
      .mem_rdata_i   (mem_rdata),
      .mem_rd_o      (mem_rd),
      .mem_wr_o      (mem_wr),
      .busy_o        (busy),
      .done_o        (done),
      .res_word_o    (res_word),
      .pc_load_o     (pc_load),
      .pc_next_o     (pc_next)
   );

   // R8: completion and redirect only happen inside a busy window
   p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done || pc_load) |-> busy);

   // R1: nothing is strobed in the first cycle out of reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !busy && !mem_rd && !mem_wr);

endmodule

// File: tb/stack_call_unit_test.sv
module stack_call_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [15:0] cmd_word = '0;
   logic [15:0] cmd_target = '0;
   logic [2:0]  cmd_vec = '0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        mem_rd, mem_wr, busy, done, pc_load;
   logic [15:0] res_word, pc_next, sp_out;

   int nchk = 0;
   int nbad = 0;
   int cyc  = 0;

   logic [7:0]  mem [0:1023];
   logic [15:0] tr_a [0:63];
   logic        tr_w [0:63];
   logic [7:0]  tr_d [0:63];
   int          tr_n = 0;
   int          dcnt = 0;

   logic [15:0] r_res, r_pcn, r_sp;
   logic        r_pcl, r_twice;
   int          r_lat;

   always #5 clk = ~clk;

   stack_call_unit uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_word(cmd_word), .cmd_target(cmd_target), .cmd_vec(cmd_vec),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
      .res_word(res_word), .pc_load(pc_load), .pc_next(pc_next), .sp_out(sp_out)
   );

   assign mem_rdata = mem[mem_addr[9:0]];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (done) dcnt <= dcnt + 1;
      if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
      if ((mem_rd || mem_wr) && tr_n < 64) begin
         tr_a[tr_n] <= mem_addr;
         tr_w[tr_n] <= mem_wr;
         tr_d[tr_n] <= mem_wr ? mem_wdata : mem_rdata;
         tr_n <= tr_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_acc(input string tag, input int idx, input logic w,
                          input logic [15:0] a, input logic [7:0] d);
      chk({tag, " kind"}, 32'(tr_w[idx]), 32'(w));
      chk({tag, " addr"}, 32'(tr_a[idx]), 32'(a));
      chk({tag, " data"}, 32'(tr_d[idx]), 32'(d));
   endtask

   task automatic run(input logic [2:0] op, input logic [15:0] w,
                      input logic [15:0] t, input logic [2:0] v);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_target = t; cmd_vec = v;
      @(negedge clk);
      cmd_valid = 1'b0;
      r_lat = 1;
      while (!done && r_lat < 20) begin
         @(negedge clk);
         r_lat++;
      end
      r_res = res_word; r_pcl = pc_load; r_pcn = pc_next; r_sp = sp_out;
      @(negedge clk);
      r_twice = done;
   endtask

   task automatic t_reset();
      chk("R1 sp", 32'(sp_out), 32'h0000);
      chk("R1 strobes", {28'd0, busy, done, mem_rd, mem_wr}, 32'd0);
      chk("R1 pc_load", 32'(pc_load), 32'd0);
   endtask

   task automatic t_setsp(input logic [15:0] v);
      int base;
      base = tr_n;
      run(3'd6, v, 16'h0, 3'd0);
      chk("R11 sp", 32'(r_sp), 32'(v));
      chk("R11 latency", 32'(r_lat), 32'd1);
      chk("R11 no access", 32'(tr_n - base), 32'd0);
   endtask

   task automatic t_push_pop();
      int base;
      base = tr_n;
      run(3'd0, 16'hA1B2, 16'h0, 3'd0);
      chk("R2 count", 32'(tr_n - base), 32'd2);
      chk_acc("R2 first", base, 1'b1, 16'h01FF, 8'hA1);
      chk_acc("R2 second", base + 1, 1'b1, 16'h01FE, 8'hB2);
      chk("R2 sp", 32'(r_sp), 32'h01FE);
      chk("R8 latency", 32'(r_lat), 32'd3);
      chk("R8 single pulse", 32'(r_twice), 32'd0);
      base = tr_n;
      run(3'd1, 16'h0, 16'h0, 3'd0);
      chk("R3 word", 32'(r_res), 32'hA1B2);
      chk_acc("R3 first", base, 1'b0, 16'h01FE, 8'hB2);
      chk_acc("R3 second", base + 1, 1'b0, 16'h01FF, 8'hA1);
      chk("R3 sp", 32'(r_sp), 32'h0200);
      chk("R3 pc_load", 32'(r_pcl), 32'd0);
   endtask

   task automatic t_call_ret();
      run(3'd2, 16'h1234, 16'h5678, 3'd0);
      chk("R4 pc_load", 32'(r_pcl), 32'd1);
      chk("R4 pc_next", 32'(r_pcn), 32'h5678);
      chk("R4 stacked", {16'd0, mem[10'h1FF], mem[10'h1FE]}, 32'h1234);
      chk("R4 sp", 32'(r_sp), 32'h01FE);
      run(3'd3, 16'h0, 16'h0, 3'd0);
      chk("R5 pc_load", 32'(r_pcl), 32'd1);
      chk("R5 pc_next", 32'(r_pcn), 32'h1234);
      chk("R5 sp", 32'(r_sp), 32'h0200);
   endtask

   task automatic t_restart();
      run(3'd4, 16'h0ABC, 16'hFFFF, 3'd5);
      chk("R6 vec5 pc", 32'(r_pcn), 32'h0028);
      chk("R6 vec5 load", 32'(r_pcl), 32'd1);
      chk("R6 stacked", {16'd0, mem[10'h1FF], mem[10'h1FE]}, 32'h0ABC);
      chk("R6 sp", 32'(r_sp), 32'h01FE);
      run(3'd4, 16'h0DEF, 16'h0000, 3'd7);
      chk("R6 vec7 pc", 32'(r_pcn), 32'h0038);
      chk("R6 sp2", 32'(r_sp), 32'h01FC);
   endtask

   task automatic t_exchange();
      int base;
      t_setsp(16'h0100);
      run(3'd0, 16'h5566, 16'h0, 3'd0);
      base = tr_n;
      run(3'd5, 16'h99AA, 16'h0, 3'd0);
      chk("R7 old top", 32'(r_res), 32'h5566);
      chk("R7 count", 32'(tr_n - base), 32'd4);
      chk_acc("R7 a0", base,     1'b0, 16'h00FE, 8'h66);
      chk_acc("R7 a1", base + 1, 1'b0, 16'h00FF, 8'h55);
      chk_acc("R7 a2", base + 2, 1'b1, 16'h00FF, 8'h99);
      chk_acc("R7 a3", base + 3, 1'b1, 16'h00FE, 8'hAA);
      chk("R7 sp", 32'(r_sp), 32'h00FE);
      chk("R8 exch latency", 32'(r_lat), 32'd5);
      run(3'd1, 16'h0, 16'h0, 3'd0);
      chk("R7 written back", 32'(r_res), 32'h99AA);
   endtask

   task automatic t_busy_ignore();
      int base;
      base = tr_n;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd0; cmd_word = 16'h1111;
      @(negedge clk);
      cmd_op = 3'd6; cmd_word = 16'h0300;
      @(negedge clk);
      @(negedge clk);
      chk("R9 done seen", 32'(done), 32'd1);
      cmd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R9 sp", 32'(sp_out), 32'h00FE);
      chk("R9 accesses", 32'(tr_n - base), 32'd2);
      chk("R9 idle", 32'(busy), 32'd0);
   endtask

   task automatic t_bad_op();
      int base, d0;
      logic [15:0] sp0;
      base = tr_n; d0 = dcnt; sp0 = sp_out;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd7; cmd_word = 16'h0055;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 accesses", 32'(tr_n - base), 32'd0);
      chk("R10 done", 32'(dcnt - d0), 32'd0);
      chk("R10 sp", 32'(sp_out), 32'(sp0));
      chk("R10 busy", 32'(busy), 32'd0);
   endtask

   task automatic t_wrap();
      int base;
      t_setsp(16'h0001);
      base = tr_n;
      run(3'd0, 16'hC3D4, 16'h0, 3'd0);
      chk_acc("R12 w0", base,     1'b1, 16'h0000, 8'hC3);
      chk_acc("R12 w1", base + 1, 1'b1, 16'hFFFF, 8'hD4);
      chk("R12 sp", 32'(r_sp), 32'hFFFF);
      run(3'd1, 16'h0, 16'h0, 3'd0);
      chk("R12 pop word", 32'(r_res), 32'hC3D4);
      chk("R12 pop sp", 32'(r_sp), 32'h0001);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setsp(16'h0200);
      t_push_pop();
      t_call_ret();
      t_setsp(16'h0200);
      t_restart();
      t_exchange();
      t_busy_ignore();
      t_bad_op();
      t_wrap();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   always @(negedge clk) begin
      if (cyc > 20000) begin
         nchk++;
         nbad++;
         $display("FAIL watchdog act=%0d exp<20000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

endmodule